// File: doc/BRIEF.md
# Adaptive-Gain Bang-Bang Loop Filter

This block is the digital loop filter of an all-digital PLL that uses a bang-bang phase detector. It runs on the reference clock and takes two inputs from the detector. The first is a held early/late sign. The second is a retimed up/down pulse that lasts one cycle. The held sign goes into a cascade of two leaky integrators. The magnitude of that average sets the loop gain, with a lower limit. A large, steady phase error therefore gives a wide loop bandwidth. A sign that toggles near lock gives a narrow one.

The retimed pulse drives a proportional kick and an integral step, and both are scaled by the adaptive gain. The integrator holds the oscillator frequency word and saturates at the rails instead of wrapping. A load input presets it to a starting frequency. A first-order delta-sigma modulator turns the signed control word into an integer oscillator code. The carry of a fractional-bit accumulator adds one code step for one cycle, so the average output keeps the fractional resolution.

Top module: `afl_loop_filter`

## Requirements
- R1: A synchronous reset clears both averaging stages, the integrator, the control word, the modulator accumulator and the oscillator code. After reset, ctrlWord and dcoWord read 0 and gainOut reads the minimum gain.
- R2: The averaging stages use signed 16-bit fixed point, where +1.0 is 0x4000. A sign input of 1 is taken as +1.0 and 0 as -1.0.
  - The first stage updates as y1 += (x - y1) >>> SHIFT_A.
  - The second stage updates as y2 += (y1 - y2) >>> SHIFT_B, using the value y1 held before the edge.
  - gainOut is max(|y2|, MIN_GAIN).
- R3: While the sign is held at either value, gainOut settles to within 2^SHIFT_A + 2^SHIFT_B of 0x4000.
- R4: While the sign alternates every cycle, gainOut settles at MIN_GAIN (default 0x0400).
- R5: Step sizes come from the gain held before the edge:
  - The proportional step is (KP_GAIN*gain) >> 14.
  - The integral step is (KI_GAIN*gain) >> 14.
  - An up pulse alone makes the next ctrlWord equal to the updated integrator plus the proportional step. A down pulse alone subtracts both steps instead.
- R6: The integral step stays in the integrator. In a cycle with no pulse, ctrlWord equals the integrator.
- R7: A cycle with both pulses, or with neither pulse, leaves the integrator unchanged.
- R8: The integrator and ctrlWord saturate at +32767 and -32768 and never wrap.
- R9: loadEn takes priority over the pulses. It sets the integrator and ctrlWord to loadWord on the next edge.
- R10: dcoWord is updated every cycle from the ctrlWord held before the edge. Its value is floor(ctrlWord / 2^FRAC_W) plus the carry of a FRAC_W-bit accumulator that adds the low FRAC_W bits of ctrlWord. While ctrlWord is held constant, any 2^FRAC_W consecutive dcoWord values sum exactly to ctrlWord.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| signLate | input | 1 | Held bang-bang sign: 1 = late (+1.0), 0 = early (-1.0) |
| upPulse | input | 1 | Retimed one-cycle up pulse |
| dnPulse | input | 1 | Retimed one-cycle down pulse |
| loadEn | input | 1 | Presets the integrator to loadWord |
| loadWord | input | CW_W | Signed initial frequency word |
| ctrlWord | output | CW_W | Signed frequency control word |
| dcoWord | output | CW_W-FRAC_W+1 | Dithered signed integer oscillator code |
| gainOut | output | DATA_W-1 | Present adaptive gain, 0x4000 = 1.0 |

## Verification
The hardest state to reach from the ports is the gain floor. There the step sizes are known exactly (16 and 2 with the defaults), so single-pulse increments can be checked by value. The stimulus gets there by first holding the sign to drive the average to full scale and then toggling it every cycle until both stages decay to a small ripple. The saturation rails are reached by presetting the integrator a few codes below the limit and then sending a run of pulses at full gain. A cycle-level arithmetic model checks every output on every cycle during a sweep over all input combinations.

// File: rtl/afl_pkg.sv
package afl_pkg;

  // Strobes from the control decode to the datapath
  typedef struct packed {
    logic stepUp;
    logic stepDn;
    logic preset;
  } afl_strobe_t;

endpackage

// File: rtl/afl_ctrl.sv
module afl_ctrl
  import afl_pkg::*;
(
  input  logic        upPulse,
  input  logic        dnPulse,
  input  logic        loadEn,
  output afl_strobe_t strobe
);

  // A preset overrides any pulse; opposing pulses cancel (R7, R9)
  always_comb begin
    strobe.preset = loadEn;
    strobe.stepUp = upPulse & ~dnPulse & ~loadEn;
    strobe.stepDn = dnPulse & ~upPulse & ~loadEn;
  end

endmodule

// File: rtl/afl_gain.sv
module afl_gain #(
  parameter int DATA_W   = 16,
  parameter int NSTAGES  = 2,
  parameter int SHIFT_A  = 3,
  parameter int SHIFT_B  = 3,
  parameter int GAIN_W   = DATA_W - 1,
  parameter int MIN_GAIN = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              signLate,
  output logic [GAIN_W-1:0] gain
);

  localparam int ONE = 1 << (DATA_W - 2);

  function automatic int shiftOf(input int s);
    return (s == 0) ? SHIFT_A : SHIFT_B;
  endfunction

  logic signed [DATA_W-1:0] xIn;
  logic signed [DATA_W-1:0] stQ   [NSTAGES];
  logic signed [DATA_W-1:0] stD   [NSTAGES];
  logic signed [DATA_W-1:0] stSrc [NSTAGES];
  logic signed [DATA_W:0]   diff  [NSTAGES];
  logic signed [DATA_W:0]   step  [NSTAGES];

  assign xIn = signLate ? DATA_W'(ONE) : DATA_W'(-ONE);

  // Leaky-integrator cascade (R2)
  always_comb begin
    for (int s = 0; s < NSTAGES; s++) begin
      if (s == 0) stSrc[s] = xIn;
      else        stSrc[s] = stQ[s-1];
      diff[s] = $signed({stSrc[s][DATA_W-1], stSrc[s]}) - $signed({stQ[s][DATA_W-1], stQ[s]});
      step[s] = diff[s] >>> shiftOf(s);
      stD[s]  = stQ[s] + step[s][DATA_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < NSTAGES; s++) begin
      if (rst) stQ[s] <= '0;
      else     stQ[s] <= stD[s];
    end
  end

  logic [DATA_W-1:0] mag;
  logic signed [DATA_W-1:0] lastQ;

  assign lastQ = stQ[NSTAGES-1];
  assign mag   = lastQ[DATA_W-1] ? DATA_W'(-lastQ) : DATA_W'(lastQ);
  assign gain  = (mag < DATA_W'(MIN_GAIN)) ? GAIN_W'(MIN_GAIN) : mag[GAIN_W-1:0];

endmodule

// File: rtl/afl_datapath.sv
module afl_datapath
  import afl_pkg::*;
#(
  parameter int CW_W      = 16,
  parameter int FRAC_W    = 6,
  parameter int GAIN_W    = 15,
  parameter int GAIN_FRAC = 14,
  parameter int KP_GAIN   = 256,
  parameter int KI_GAIN   = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  afl_strobe_t                strobe,
  input  logic [GAIN_W-1:0]          gain,
  input  logic signed [CW_W-1:0]     loadWord,
  output logic signed [CW_W-1:0]     ctrlWord,
  output logic signed [CW_W-FRAC_W:0] dcoWord
);

  localparam int EXT_W  = CW_W + 2;
  localparam int PROD_W = CW_W + GAIN_W;
  localparam int INT_W  = CW_W - FRAC_W;
  localparam logic [CW_W-1:0] KPV = CW_W'(KP_GAIN);
  localparam logic [CW_W-1:0] KIV = CW_W'(KI_GAIN);
  localparam logic signed [EXT_W-1:0] MAXE = EXT_W'((1 << (CW_W - 1)) - 1);
  localparam logic signed [EXT_W-1:0] MINE = EXT_W'(-(1 << (CW_W - 1)));

  function automatic logic signed [CW_W-1:0] clampCw(input logic signed [EXT_W-1:0] v);
    if (v > MAXE)      return MAXE[CW_W-1:0];
    else if (v < MINE) return MINE[CW_W-1:0];
    else               return v[CW_W-1:0];
  endfunction

  // Gain-scaled step sizes (R5)
  logic [PROD_W-1:0] pProd, iProd;
  logic [CW_W-1:0]   pStep, iStep;

  assign pProd = {{GAIN_W{1'b0}}, KPV} * {{CW_W{1'b0}}, gain};
  assign iProd = {{GAIN_W{1'b0}}, KIV} * {{CW_W{1'b0}}, gain};
  assign pStep = pProd[GAIN_FRAC +: CW_W];
  assign iStep = iProd[GAIN_FRAC +: CW_W];

  logic signed [EXT_W-1:0] pDelta, iDelta, integSum, ctrlSum;
  logic signed [CW_W-1:0]  integQ, integNext, ctrlNext;

  always_comb begin
    if (strobe.stepUp) begin
      pDelta = $signed({2'b00, pStep});
      iDelta = $signed({2'b00, iStep});
    end else if (strobe.stepDn) begin
      pDelta = -$signed({2'b00, pStep});
      iDelta = -$signed({2'b00, iStep});
    end else begin
      pDelta = '0;
      iDelta = '0;
    end
    // Saturating integral then proportional kick (R6, R8)
    integSum  = $signed({{2{integQ[CW_W-1]}}, integQ}) + iDelta;
    integNext = clampCw(integSum);
    ctrlSum   = $signed({{2{integNext[CW_W-1]}}, integNext}) + pDelta;
    ctrlNext  = clampCw(ctrlSum);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      integQ   <= '0;
      ctrlWord <= '0;
    end else if (strobe.preset) begin
      integQ   <= loadWord;
      ctrlWord <= loadWord;
    end else begin
      integQ   <= integNext;
      ctrlWord <= ctrlNext;
    end
  end

  // First-order error-feedback modulator on the fractional bits (R10)
  logic [FRAC_W-1:0] accQ;
  logic [FRAC_W:0]   fracSum;
  logic signed [INT_W:0] intPart;

  assign fracSum = {1'b0, accQ} + {1'b0, ctrlWord[FRAC_W-1:0]};
  assign intPart = $signed({ctrlWord[CW_W-1], ctrlWord[CW_W-1:FRAC_W]});

  always_ff @(posedge clk) begin
    if (rst) begin
      accQ    <= '0;
      dcoWord <= '0;
    end else begin
      accQ    <= fracSum[FRAC_W-1:0];
      dcoWord <= intPart + $signed({{INT_W{1'b0}}, fracSum[FRAC_W]});
    end
  end

endmodule

// File: rtl/afl_loop_filter.sv
module afl_loop_filter
  import afl_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int SHIFT_A  = 3,
  parameter int SHIFT_B  = 3,
  parameter int MIN_GAIN = 1024,
  parameter int CW_W     = 16,
  parameter int FRAC_W   = 6,
  parameter int KP_GAIN  = 256,
  parameter int KI_GAIN  = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         signLate,
  input  logic                         upPulse,
  input  logic                         dnPulse,
  input  logic                         loadEn,
  input  logic signed [CW_W-1:0]       loadWord,
  output logic signed [CW_W-1:0]       ctrlWord,
  output logic signed [CW_W-FRAC_W:0]  dcoWord,
  output logic [DATA_W-2:0]            gainOut
);

  localparam int GAIN_W = DATA_W - 1;

  afl_strobe_t strobe;

  afl_ctrl u_ctrl (
    .upPulse (upPulse),
    .dnPulse (dnPulse),
    .loadEn  (loadEn),
    .strobe  (strobe)
  );

  afl_gain #(
    .DATA_W   (DATA_W),
    .NSTAGES  (2),
    .SHIFT_A  (SHIFT_A),
    .SHIFT_B  (SHIFT_B),
    .GAIN_W   (GAIN_W),
    .MIN_GAIN (MIN_GAIN)
  ) u_gain (
    .clk      (clk),
    .rst      (rst),
    .signLate (signLate),
    .gain     (gainOut)
  );

  afl_datapath #(
    .CW_W      (CW_W),
    .FRAC_W    (FRAC_W),
    .GAIN_W    (GAIN_W),
    .GAIN_FRAC (DATA_W - 2),
    .KP_GAIN   (KP_GAIN),
    .KI_GAIN   (KI_GAIN)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .gain     (gainOut),
    .loadWord (loadWord),
    .ctrlWord (ctrlWord),
    .dcoWord  (dcoWord)
  );

endmodule

// File: rtl/afl_loop_filter_chk.sv
module afl_loop_filter_chk #(
  parameter int CW_W     = 16,
  parameter int FRAC_W   = 6,
  parameter int GAIN_W   = 15,
  parameter int MIN_GAIN = 1024,
  parameter int ONE      = 16384
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        upPulse,
  input logic                        dnPulse,
  input logic                        loadEn,
  input logic signed [CW_W-1:0]      loadWord,
  input logic signed [CW_W-1:0]      ctrlWord,
  input logic signed [CW_W-FRAC_W:0] dcoWord,
  input logic [GAIN_W-1:0]           gainOut
);

  logic signed [CW_W-FRAC_W:0] intNow;
  logic quiet;

  assign intNow = $signed({ctrlWord[CW_W-1], ctrlWord[CW_W-1:FRAC_W]});
  assign quiet  = !loadEn && (upPulse == dnPulse);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ctrlWord == '0 && dcoWord == '0));

  // R2
  gain_range_chk: assert property (@(posedge clk) disable iff (rst)
    (gainOut >= GAIN_W'(MIN_GAIN)) && (gainOut <= GAIN_W'(ONE)));

  // R7
  quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (quiet && $past(quiet)) |=> $stable(ctrlWord));

  // R9
  preset_load_chk: assert property (@(posedge clk) disable iff (rst)
    loadEn |=> (ctrlWord == $past(loadWord)));

  // R10
  dither_range_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (dcoWord == $past(intNow) || dcoWord == $past(intNow) + 1));

endmodule

bind afl_loop_filter afl_loop_filter_chk #(
  .CW_W     (CW_W),
  .FRAC_W   (FRAC_W),
  .GAIN_W   (DATA_W - 1),
  .MIN_GAIN (MIN_GAIN),
  .ONE      (1 << (DATA_W - 2))
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .upPulse  (upPulse),
  .dnPulse  (dnPulse),
  .loadEn   (loadEn),
  .loadWord (loadWord),
  .ctrlWord (ctrlWord),
  .dcoWord  (dcoWord),
  .gainOut  (gainOut)
);

// File: tb/afl_loop_filter_bench.sv
`timescale 1ns/100ps
module afl_loop_filter_bench;

  localparam int ONE  = 16384;
  localparam int MING = 1024;
  localparam int KP   = 256;
  localparam int KI   = 32;
  localparam int SA   = 3;
  localparam int SB   = 3;
  localparam int FW   = 6;
  localparam int CMAX = 32767;
  localparam int CMIN = -32768;

  logic clk = 0;
  logic rst = 1;
  logic signLate = 0, upPulse = 0, dnPulse = 0, loadEn = 0;
  logic signed [15:0] loadWord = '0;
  logic signed [15:0] ctrlWord;
  logic signed [10:0] dcoWord;
  logic [14:0] gainOut;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";
  bit altMode = 0;

  int mY1 = 0, mY2 = 0, mInteg = 0, mCtrl = 0, mAcc = 0, mDco = 0;

  always #2.5 clk = ~clk;

  afl_loop_filter u_afl_loop_filter (
    .clk(clk), .rst(rst), .signLate(signLate), .upPulse(upPulse),
    .dnPulse(dnPulse), .loadEn(loadEn), .loadWord(loadWord),
    .ctrlWord(ctrlWord), .dcoWord(dcoWord), .gainOut(gainOut)
  );

  function automatic int sat(input int v);
    if (v > CMAX) return CMAX;
    if (v < CMIN) return CMIN;
    return v;
  endfunction

  function automatic int modelGain(input int y);
    int m;
    m = (y < 0) ? -y : y;
    return (m < MING) ? MING : m;
  endfunction

  task automatic modelStep();
    int x, g, p, i, e, ny1, ny2, ni, nc, sum;
    if (rst) begin
      mY1 = 0; mY2 = 0; mInteg = 0; mCtrl = 0; mAcc = 0; mDco = 0;
      return;
    end
    x   = signLate ? ONE : -ONE;
    ny1 = mY1 + ((x - mY1) >>> SA);
    ny2 = mY2 + ((mY1 - mY2) >>> SB);
    g   = modelGain(mY2);
    p   = (KP * g) >> 14;
    i   = (KI * g) >> 14;
    e   = (upPulse && !dnPulse) ? 1 : (dnPulse && !upPulse) ? -1 : 0;
    sum  = mAcc + (mCtrl & 63);
    mDco = (mCtrl >>> FW) + (sum >> FW);
    mAcc = sum & 63;
    if (loadEn) begin
      ni = int'(loadWord);
      nc = ni;
    end else begin
      ni = sat(mInteg + e * i);
      nc = sat(ni + e * p);
    end
    mY1 = ny1; mY2 = ny2; mInteg = ni; mCtrl = nc;
  endtask

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic tick();
    if (altMode) signLate = ~signLate;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    check({curReq, " ctrlWord"}, int'(ctrlWord), mCtrl);
    check({curReq, " dcoWord"},  int'(dcoWord),  mDco);
    check({curReq, " gainOut"},  int'(gainOut),  modelGain(mY2));
  endtask

  task automatic pulse(input logic u, input logic d);
    upPulse = u; dnPulse = d;
    tick();
    upPulse = 0; dnPulse = 0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c0, s;
    @(negedge clk);
    rst = 1;
    repeat (3) tick();
    rst = 0;
    // R1: reset state
    check("R1 ctrlWord", int'(ctrlWord), 0);
    check("R1 dcoWord", int'(dcoWord), 0);
    check("R1 gainOut", int'(gainOut), MING);
    tick();

    // R3: held sign, both polarities
    curReq = "R3"; signLate = 1;
    repeat (150) tick();
    check("R3 gain late", (int'(gainOut) >= ONE - (1 << SA) - (1 << SB)) ? 1 : 0, 1);
    signLate = 0;
    repeat (150) tick();
    check("R3 gain early", (int'(gainOut) >= ONE - (1 << SA) - (1 << SB)) ? 1 : 0, 1);

    // R2 and R5: sweep all input combinations against the model
    curReq = "R2";
    for (int k = 0; k < 1024; k++) begin
      signLate = k[0] ^ k[5];
      upPulse  = k[1];
      dnPulse  = k[2];
      loadEn   = (k[4:1] == 4'b1011);
      loadWord = 16'(k * 61 - 30000);
      tick();
    end
    upPulse = 0; dnPulse = 0; loadEn = 0;

    // R4: toggling sign drives gain to the floor
    curReq = "R4"; altMode = 1;
    repeat (200) tick();
    check("R4 gain floor", int'(gainOut), MING);

    // R5/R6 at floor gain: steps 16 and 2
    curReq = "R5";
    repeat (2) tick();
    c0 = int'(ctrlWord);
    pulse(1, 0);
    check("R5 up kick", int'(ctrlWord), c0 + 18);
    tick();
    check("R6 up kept", int'(ctrlWord), c0 + 2);
    c0 = int'(ctrlWord);
    pulse(0, 1);
    check("R5 down kick", int'(ctrlWord), c0 - 18);
    tick();
    check("R6 down kept", int'(ctrlWord), c0 - 2);

    // R7: opposing pulses cancel
    curReq = "R7";
    c0 = int'(ctrlWord);
    pulse(1, 1);
    check("R7 both pulses", int'(ctrlWord), c0);
    tick();
    check("R7 no pulse", int'(ctrlWord), c0);
    altMode = 0;

    // R8: saturation at both rails with full gain
    curReq = "R8"; signLate = 1;
    repeat (100) tick();
    loadEn = 1; loadWord = 16'(CMAX - 5); tick(); loadEn = 0;
    for (int k = 0; k < 20; k++) begin
      pulse(1, 0);
      check("R8 top rail", int'(ctrlWord), CMAX);
    end
    tick();
    check("R8 top integ", int'(ctrlWord), CMAX);
    loadEn = 1; loadWord = 16'(CMIN + 5); tick(); loadEn = 0;
    for (int k = 0; k < 20; k++) begin
      pulse(0, 1);
      check("R8 bottom rail", int'(ctrlWord), CMIN);
    end
    tick();
    check("R8 bottom integ", int'(ctrlWord), CMIN);

    // R9: preset overrides pulses
    curReq = "R9";
    for (int k = 0; k < 16; k++) begin
      loadEn = 1; loadWord = 16'(k * 4099 - 31000);
      upPulse = k[0]; dnPulse = k[1];
      tick();
      loadEn = 0; upPulse = 0; dnPulse = 0;
      check("R9 preset", int'(ctrlWord), k * 4099 - 31000);
    end

    // R10: dither average over 64 cycles
    curReq = "R10";
    for (int k = 0; k < 6; k++) begin
      c0 = (k * 9871 - 25000) % 32768;
      loadEn = 1; loadWord = 16'(c0); tick(); loadEn = 0;
      repeat (2) tick();
      s = 0;
      for (int j = 0; j < 64; j++) begin
        tick();
        s += int'(dcoWord);
      end
      check("R10 dither sum", s, c0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule